// File: doc/BRIEF.md
# ALU with Condition Code Register

This block is an 8-bit arithmetic and logic unit joined to an 8-bit condition code register. Each accepted operation produces a result and a set of candidate flags. A per-operation write mask then picks which flags reach the register on the same clock edge. Some classes write no flags at all. The 16-bit index step writes only zero. Compare writes the same flags as subtract but never writes a result back. The two rotates pass data through the carry flag, so a shift across several bytes can be built from a chain of single-byte rotates.

Besides the operation path, the register has two side inputs. A dedicated port writes the stop-disable bit and both interrupt mask bits. An external error strobe sets carry on behalf of a multiply or divide unit that lives elsewhere. The interrupt mask bit is driven out as a plain control pin.

The operation input is a valid-qualified stream with no back-pressure. The block accepts an operation in every cycle where `in_valid` is high. One cycle later it presents the registered result together with `res_we`, and the consumer must take every result while `res_we` is high. Register bit order, from bit 7 down to bit 0, is S, X, H, I, N, Z, V, C.

Top module: `alu_ccr`

## Requirements
- R1: After reset the register reads 0xD0 (S, X and I set; H, N, Z, V, C clear), `res_we` is low and `irq_mask` is high.
- R2: Add (op 0) produces a+b+cin. C is the carry out of bit 7 and H is the carry out of bit 3. V is set on signed overflow. N is result bit 7 and Z marks a zero result.
- R3: Subtract (op 1) produces a-b-cin. C is set on borrow and V on signed overflow. N and Z follow the result, and H is held.
- R4: Compare (op 2) writes N, Z, V and C exactly as a subtract of a-b with no carry in, holds H, and leaves `res_we` low.
- R5: AND (op 3), OR (op 4) and XOR (op 5) write the result, set N and Z from it, clear V, and hold C and H.
- R6: Load pass-through (op 6) outputs operand a, sets N and Z from it, clears V, and holds C and H.
- R7: Rotate left (op 7) outputs {a[6:0], C} and moves a[7] into C. Rotate right (op 8) outputs {C, a[7:1]} and moves a[0] into C. For both, N and Z follow the result, V becomes N xor the new C, and H is held.
- R8: Index increment (op 9) and decrement (op 10) take the 16-bit operand {b, a}. They output that operand plus or minus one on all 16 result bits and set Z only when all 16 bits are zero. Every other register bit is held.
- R9: The no-flag class (op 11, and codes 12 to 15) outputs operand a with `res_we` high and leaves every register bit unchanged.
- R10: An `err_strobe` pulse sets C on the next edge. It overrides any C value the operation in the same cycle would write.
- R11: A `mask_we` pulse loads `mask_din[2]`, `mask_din[1]` and `mask_din[0]` into S, X and I respectively. `irq_mask` always equals I.
- R12: With `in_valid`, `err_strobe` and `mask_we` all low, the register does not change and `res_we` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe; the operation is accepted on this edge |
| op | input | 4 | Operation class code |
| opa | input | 8 | Operand a; low byte of the index operand |
| opb | input | 8 | Operand b; high byte of the index operand |
| cin | input | 1 | Carry in for add and subtract |
| err_strobe | input | 1 | Sets C for an external multiply/divide error |
| mask_we | input | 1 | Write strobe for S, X and I |
| mask_din | input | 3 | New {S, X, I} values |
| res | output | 16 | Registered result (upper byte zero for 8-bit operations) |
| res_we | output | 1 | Result write-enable, one cycle after acceptance |
| ccr | output | 8 | Full condition code register |
| irq_mask | output | 1 | Maskable interrupt mask (I bit) |

## Verification
Some properties are checked on every cycle. Idle cycles leave the register unchanged. The error strobe always lands in C. A mask write always lands in S, X and I. The index step and the no-flag class disturb nothing outside their write masks. Compare never raises the write-enable. Logic operations hold C and H and clear V. The exact arithmetic values can only be shown by the bench's scenarios. These are the carry, half-carry, borrow and overflow values on chosen operands, the bit that rotates through carry, the 16-bit wrap of the index step, and the override when the error strobe collides with an operation.

// File: rtl/alu_ccr_pkg.sv
package alu_ccr_pkg;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = 2 * DATA_W;
  localparam int CCR_W   = 8;
  localparam int FLAG_N  = 5;

  // register bit positions
  localparam int POS_C = 0;
  localparam int POS_V = 1;
  localparam int POS_Z = 2;
  localparam int POS_N = 3;
  localparam int POS_I = 4;
  localparam int POS_H = 5;
  localparam int POS_X = 6;
  localparam int POS_S = 7;

  localparam logic [CCR_W-1:0] CCR_RESET = 8'hD0;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_CMP   = 4'd2,
    OP_AND   = 4'd3,
    OP_OR    = 4'd4,
    OP_XOR   = 4'd5,
    OP_LOAD  = 4'd6,
    OP_ROL   = 4'd7,
    OP_ROR   = 4'd8,
    OP_INC16 = 4'd9,
    OP_DEC16 = 4'd10,
    OP_PASS  = 4'd11
  } alu_op_e;

  // flag vector index i maps to register bit flag_pos(i): {H,N,Z,V,C}
  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  function automatic int flag_pos(input int i);
    return (i == FLAG_N - 1) ? POS_H : i;
  endfunction
endpackage

// File: rtl/alu_flag_mask.sv
module alu_flag_mask
  import alu_ccr_pkg::*;
(
  input  alu_op_e op,
  output flags_t  wmask
);
  always_comb begin
    unique case (op)
      OP_ADD:                   wmask = '{h: 1'b1, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
      OP_SUB, OP_CMP,
      OP_ROL, OP_ROR:           wmask = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
      OP_AND, OP_OR, OP_XOR,
      OP_LOAD:                  wmask = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b0};
      OP_INC16, OP_DEC16:       wmask = '{h: 1'b0, n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};
      default:                  wmask = '0;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_ccr_pkg::*;
#(
  parameter int DW = DATA_W,
  localparam int IW = 2 * DW
) (
  input  alu_op_e        op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic           cin,
  input  logic           c_cur,
  output logic [IW-1:0]  res,
  output logic           res_we,
  output flags_t         cand
);
  localparam int HB = DW / 2;

  logic [DW:0]   sum_w;
  logic [DW:0]   dif_w;
  logic [HB:0]   half_w;
  logic          sub_cin;
  logic [IW-1:0] idx_w;
  logic [DW-1:0] r8;
  logic          c_new;
  logic          v_new;

  assign sub_cin = (op == OP_SUB) ? cin : 1'b0;
  assign sum_w   = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
  assign dif_w   = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, sub_cin};
  assign half_w  = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]} + {{HB{1'b0}}, cin};
  assign idx_w   = {b, a};

  always_comb begin
    r8     = a;
    c_new  = c_cur;
    v_new  = 1'b0;
    res_we = 1'b1;
    res    = '0;
    unique case (op)
      OP_ADD: begin
        r8    = sum_w[DW-1:0];
        c_new = sum_w[DW];
        v_new = (a[DW-1] == b[DW-1]) && (sum_w[DW-1] != a[DW-1]);
      end
      OP_SUB, OP_CMP: begin
        r8     = dif_w[DW-1:0];
        c_new  = dif_w[DW];
        v_new  = (a[DW-1] != b[DW-1]) && (dif_w[DW-1] != a[DW-1]);
        res_we = (op == OP_SUB);
      end
      OP_AND:  r8 = a & b;
      OP_OR:   r8 = a | b;
      OP_XOR:  r8 = a ^ b;
      OP_ROL: begin
        r8    = {a[DW-2:0], c_cur};
        c_new = a[DW-1];
        v_new = r8[DW-1] ^ c_new;
      end
      OP_ROR: begin
        r8    = {c_cur, a[DW-1:1]};
        c_new = a[0];
        v_new = r8[DW-1] ^ c_new;
      end
      default: r8 = a;
    endcase

    if (op == OP_INC16)      res = idx_w + 1'b1;
    else if (op == OP_DEC16) res = idx_w - 1'b1;
    else                     res = {{DW{1'b0}}, r8};
  end

  assign cand.h = half_w[HB];
  assign cand.n = r8[DW-1];
  assign cand.z = (res == '0);
  assign cand.v = v_new;
  assign cand.c = c_new;
endmodule

// File: rtl/alu_ccr_reg.sv
module alu_ccr_reg
  import alu_ccr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  flags_t           wmask,
  input  flags_t           cand,
  input  logic             err,
  input  logic             mask_we,
  input  logic [2:0]       mask_din,
  output logic [CCR_W-1:0] ccr_q
);
  logic [FLAG_N-1:0] wm_v;
  logic [FLAG_N-1:0] cd_v;
  logic [CCR_W-1:0]  flag_d;
  logic [CCR_W-1:0]  ccr_d;

  assign wm_v = wmask;
  assign cd_v = cand;

  for (genvar gi = 0; gi < CCR_W; gi++) begin : g_bit
    if (gi == POS_I || gi == POS_X || gi == POS_S) begin : g_mask_bit
      assign flag_d[gi] = ccr_q[gi];
    end else begin : g_flag_bit
      localparam int FI = (gi == POS_H) ? FLAG_N - 1 : gi;
      assign flag_d[gi] = (upd && wm_v[FI]) ? cd_v[FI] : ccr_q[gi];
    end
  end

  always_comb begin
    ccr_d = flag_d;
    if (err) ccr_d[POS_C] = 1'b1;
    if (mask_we) begin
      ccr_d[POS_S] = mask_din[2];
      ccr_d[POS_X] = mask_din[1];
      ccr_d[POS_I] = mask_din[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ccr_q <= CCR_RESET;
    else        ccr_q <= ccr_d;
  end

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !err && !mask_we) |=> (ccr_q == $past(ccr_q)));

  // R10
  err_sets_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> ccr_q[POS_C]);

  // R11
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> ({ccr_q[POS_S], ccr_q[POS_X], ccr_q[POS_I]} == $past(mask_din)));

  // R9
  nomask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && (wmask == '0) && !err && !mask_we) |=> (ccr_q == $past(ccr_q)));
endmodule

// File: rtl/alu_ccr.sv
module alu_ccr
  import alu_ccr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [3:0]           op,
  input  logic [DATA_W-1:0]    opa,
  input  logic [DATA_W-1:0]    opb,
  input  logic                 cin,
  input  logic                 err_strobe,
  input  logic                 mask_we,
  input  logic [2:0]           mask_din,
  output logic [IDX_W-1:0]     res,
  output logic                 res_we,
  output logic [CCR_W-1:0]     ccr,
  output logic                 irq_mask
);
  alu_op_e       op_e;
  flags_t        wmask;
  flags_t        cand;
  logic [IDX_W-1:0] res_c;
  logic          we_c;
  logic [IDX_W-1:0] res_q;
  logic          res_we_q;
  logic [CCR_W-1:0] ccr_q;

  assign op_e = alu_op_e'(op);

  alu_flag_mask u_mask (
    .op    (op_e),
    .wmask (wmask)
  );

  alu_datapath #(.DW(DATA_W)) u_dp (
    .op     (op_e),
    .a      (opa),
    .b      (opb),
    .cin    (cin),
    .c_cur  (ccr_q[POS_C]),
    .res    (res_c),
    .res_we (we_c),
    .cand   (cand)
  );

  alu_ccr_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (in_valid),
    .wmask    (wmask),
    .cand     (cand),
    .err      (err_strobe),
    .mask_we  (mask_we),
    .mask_din (mask_din),
    .ccr_q    (ccr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q    <= '0;
      res_we_q <= 1'b0;
    end else begin
      res_we_q <= in_valid && we_c;
      if (in_valid && we_c) res_q <= res_c;
    end
  end

  assign res      = res_q;
  assign res_we   = res_we_q;
  assign ccr      = ccr_q;
  assign irq_mask = ccr_q[POS_I];

  // R4
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == OP_CMP) |=> !res_we);

  // R8
  idx_only_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_e == OP_INC16 || op_e == OP_DEC16) && !err_strobe && !mask_we)
      |=> ((ccr & ~(8'h1 << POS_Z)) == ($past(ccr) & ~(8'h1 << POS_Z))));

  // R5
  logic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_e == OP_AND || op_e == OP_OR || op_e == OP_XOR) && !err_strobe)
      |=> (ccr[POS_C] == $past(ccr[POS_C]) && ccr[POS_H] == $past(ccr[POS_H]) && !ccr[POS_V]));

  // R12
  idle_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_we);
endmodule

// File: tb/test_alu_ccr.sv
module test_alu_ccr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [7:0]  opa = '0;
  logic [7:0]  opb = '0;
  logic        cin = 1'b0;
  logic        err_strobe = 1'b0;
  logic        mask_we = 1'b0;
  logic [2:0]  mask_din = '0;
  logic [15:0] res;
  logic        res_we;
  logic [7:0]  ccr;
  logic        irq_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_ccr i_alu_ccr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
    .cin(cin), .err_strobe(err_strobe), .mask_we(mask_we), .mask_din(mask_din),
    .res(res), .res_we(res_we), .ccr(ccr), .irq_mask(irq_mask)
  );

  // {op, a, b, cin, res, we, H N Z V C}
  localparam logic [34:0] VEC [15] = '{
    {4'd0,  8'h0F, 8'h01, 1'b0, 8'h10, 1'b1, 5'b10000}, // R2 half carry
    {4'd0,  8'h7F, 8'h01, 1'b0, 8'h80, 1'b1, 5'b11010}, // R2 overflow
    {4'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 5'b10101}, // R2 carry, zero
    {4'd3,  8'hF0, 8'h0F, 1'b0, 8'h00, 1'b1, 5'b10101}, // R5 AND holds C,H
    {4'd7,  8'h80, 8'h00, 1'b0, 8'h01, 1'b1, 5'b10011}, // R7 rotate left
    {4'd8,  8'h02, 8'h00, 1'b0, 8'h81, 1'b1, 5'b11010}, // R7 rotate right
    {4'd1,  8'h10, 8'h20, 1'b0, 8'hF0, 1'b1, 5'b11001}, // R3 borrow
    {4'd1,  8'h80, 8'h01, 1'b0, 8'h7F, 1'b1, 5'b10010}, // R3 overflow
    {4'd6,  8'h80, 8'h00, 1'b0, 8'h80, 1'b1, 5'b11000}, // R6 load clears V
    {4'd2,  8'h42, 8'h42, 1'b0, 8'h00, 1'b0, 5'b10100}, // R4 compare
    {4'd0,  8'h01, 8'h01, 1'b1, 8'h03, 1'b1, 5'b00000}, // R2 carry in
    {4'd11, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 5'b00000}, // R9 no-flag class
    {4'd4,  8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 5'b00100}, // R5 OR
    {4'd5,  8'hAA, 8'h55, 1'b0, 8'hFF, 1'b1, 5'b01000}, // R5 XOR
    {4'd1,  8'h00, 8'h00, 1'b1, 8'hFF, 1'b1, 5'b01001}  // R3 borrow from cin
  };

  function automatic logic [7:0] mk_ccr(input logic [2:0] sxi, input logic [4:0] f);
    return {sxi[2], sxi[1], f[4], sxi[0], f[3:0]};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic c, input logic v, input logic e);
    @(negedge clk);
    op = o; opa = a; opb = b; cin = c; in_valid = v; err_strobe = e;
    @(negedge clk);
    in_valid = 1'b0; err_strobe = 1'b0;
  endtask

  initial begin
    #(5 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "ccr reset", ccr, 8'hD0);
    check("R1", "res_we reset", res_we, 1'b0);
    check("R1", "irq_mask reset", irq_mask, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 15; k++) begin
      logic [34:0] e;
      e = VEC[k];
      apply(e[34:31], e[30:23], e[22:15], e[14], 1'b1, 1'b0);
      if (e[5]) check("R2-7 vec", "res", res, {8'h00, e[13:6]});
      check("R2-9 vec", "res_we", res_we, e[5]);
      check("R2-9 vec", "ccr", ccr, mk_ccr(3'b111, e[4:0]));
    end
    // flags now H0 N1 Z0 V0 C1

    // R8 increment wraps to zero, only Z written
    apply(4'd9, 8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0);
    check("R8", "inc res", res, 16'h0000);
    check("R8", "inc ccr", ccr, mk_ccr(3'b111, 5'b01101));
    // R8 decrement 0x0100 -> 0x00FF, Z on full 16 bits
    apply(4'd10, 8'h00, 8'h01, 1'b0, 1'b1, 1'b0);
    check("R8", "dec res", res, 16'h00FF);
    check("R8", "dec ccr", ccr, mk_ccr(3'b111, 5'b01001));

    // R12 idle: operands present, valid low
    apply(4'd0, 8'hFF, 8'h01, 1'b1, 1'b0, 1'b0);
    check("R12", "idle ccr", ccr, mk_ccr(3'b111, 5'b01001));
    check("R12", "idle res_we", res_we, 1'b0);

    // clear C with a zero add, then R10 strobe alone and colliding
    apply(4'd0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    check("R2", "zero add ccr", ccr, mk_ccr(3'b111, 5'b00100));
    apply(4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R10", "strobe alone", ccr, mk_ccr(3'b111, 5'b00101));
    apply(4'd0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    apply(4'd0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1);
    check("R10", "strobe overrides add", ccr, mk_ccr(3'b111, 5'b00101));

    // R11 mask write
    @(negedge clk);
    mask_we = 1'b1; mask_din = 3'b010;
    @(negedge clk);
    mask_we = 1'b0;
    check("R11", "mask ccr", ccr, mk_ccr(3'b010, 5'b00101));
    check("R11", "irq_mask", irq_mask, 1'b0);
    @(negedge clk);
    mask_we = 1'b1; mask_din = 3'b101;
    @(negedge clk);
    mask_we = 1'b0;
    check("R11", "mask ccr 2", ccr, mk_ccr(3'b101, 5'b00101));
    check("R11", "irq_mask 2", irq_mask, 1'b1);

    // R9 reserved code behaves as no-flag class
    apply(4'd14, 8'h80, 8'h00, 1'b0, 1'b1, 1'b0);
    check("R9", "reserved res", res, 16'h0080);
    check("R9", "reserved ccr", ccr, mk_ccr(3'b101, 5'b00101));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule